// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. A program counter addresses an instruction memory that answers combinationally within the same cycle. The fetched word is split into fixed fields. The core reads two operands from a register file, adds them in an ALU or compares them, and writes the result back at the next edge. A single data memory port carries a word address, write data and separate read and write strobes. Load data is expected back within the same cycle.

The instruction set has four members. ADD adds two registers. LOAD and STORE address memory as a base register plus a signed offset. BEQ is a branch relative to the program counter that is taken when two registers are equal. Every other opcode does nothing except advance the program counter. The core is meant to be embedded with tightly coupled instruction and data memories, for example as a sequencer inside a larger chip.

Top module: `sc_core`

## Requirements
- R1: The instruction word is decoded with the opcode in bits 31..26, the first source register in 25..21, the second source register in 20..16, the destination register in 15..11 and an 11-bit immediate in 10..0. The opcode values are ADD=6'h00, BEQ=6'h04, LOAD=6'h23 and STORE=6'h2B.
- R2: ADD writes the sum of the two source registers (modulo 2^32) into the destination register at the clock edge. It raises neither memory strobe.
- R3: LOAD raises the read strobe and drives the address as the base register (first source) plus the offset. At the edge it writes the returned data into the register named by the destination field. The write strobe stays low.
- R4: STORE raises the write strobe and drives the address as base plus offset. The write data is the second source register. The read strobe stays low and no register is written.
- R5: The 11-bit immediate is sign-extended from bit 10 to 32 bits before it is used as an offset.
- R6: Register 0 reads as zero in every instruction, and any write aimed at it is discarded.
- R7: A synchronous active-high reset sets the program counter to 0. Outside reset, every instruction other than a taken BEQ advances it by 4.
- R8: BEQ raises no strobe and writes no register. When the two source registers are equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by two. Otherwise it is PC+4.
- R9: An opcode outside the four listed acts as a no-op: no strobe, no register write, PC+4.
- R10: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (program counter) |
| imem_data | input | 32 | Instruction word for imem_addr, same cycle |
| dmem_addr | output | 32 | Data memory byte address (base plus offset) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data for dmem_addr, same cycle |
| dmem_rd | output | 1 | Read strobe, high during a LOAD |
| dmem_wr | output | 1 | Write strobe, high during a STORE |

## Verification
A short directed program runs first. It loads two distinct words, one of them through a negative offset, and adds them. It writes to register 0 and stores from it, then takes one BEQ and falls through another. These cases separate a correct sign extension, a correct zero register and a correct branch decision from the plausible mistakes in each. After that, long random programs mix all four instructions with undefined opcodes over eight registers. They use full-range offsets and short branches in both directions. The random mix catches wrong operand selection, wrong writeback selection and wrong destination fields, because every store and every fetch address exposes state that earlier instructions built.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 11;

    // field positions of the fixed instruction layout
    localparam int OPC_LSB = 26;
    localparam int RS1_LSB = 21;
    localparam int RS2_LSB = 16;
    localparam int RD_LSB  = 11;

    localparam logic [OPC_W-1:0] OP_ADD   = 6'h00;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    typedef enum logic {
        ALU_ADD = 1'b0,
        ALU_SUB = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic    sel_imm;     // second ALU operand: immediate instead of register
        logic    mem_rd;
        logic    mem_wr;
        logic    wb_mem;      // writeback from load data instead of ALU
        logic    reg_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        sel_imm: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0, wb_mem: 1'b0,
        reg_we: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD
    };

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [RIDX_W-1:0]  rs1,
    output logic [RIDX_W-1:0]  rs2,
    output logic [RIDX_W-1:0]  rd,
    output logic [XLEN-1:0]    imm_ext
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [OPC_W-1:0] opc;
    logic [IMM_W-1:0] imm_raw;

    always_comb begin
        opc     = instr[OPC_LSB +: OPC_W];
        rs1     = instr[RS1_LSB +: RIDX_W];
        rs2     = instr[RS2_LSB +: RIDX_W];
        rd      = instr[RD_LSB  +: RIDX_W];
        imm_raw = instr[IMM_W-1:0];
        imm_ext = {{EXT_W{imm_raw[IMM_W-1]}}, imm_raw};
    end

    always_comb begin
        ctrl = CTRL_IDLE;
        unique case (opc)
            OP_ADD: begin
                ctrl.reg_we = 1'b1;
            end
            OP_LOAD: begin
                ctrl.sel_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
                ctrl.wb_mem  = 1'b1;
                ctrl.reg_we  = 1'b1;
            end
            OP_STORE: begin
                ctrl.sel_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl = CTRL_IDLE;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ra1,
    input  logic [RIDX_W-1:0] ra2,
    input  logic [RIDX_W-1:0] wa,
    input  logic [XLEN-1:0]   wd,
    input  logic              we,
    output logic [XLEN-1:0]   rd1,
    output logic [XLEN-1:0]   rd2
);

    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (wa != '0) && (int'(wa) < NREGS)) begin
            regs_d[wa] = wd;
        end
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            regs_q[i] <= regs_d[i];
        end
    end

    // index 0 and out-of-range indices read as zero
    always_comb begin
        rd1 = (ra1 == '0 || int'(ra1) >= NREGS) ? '0 : regs_q[ra1];
        rd2 = (ra2 == '0 || int'(ra2) >= NREGS) ? '0 : regs_q[ra2];
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: res = opa - opb;
            default: res = opa + opb;
        endcase
        zero = (res == '0);
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 32
) (
    input  logic                clk,
    input  logic                rst,
    output logic [XLEN-1:0]     imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [XLEN-1:0]     dmem_addr,
    output logic [XLEN-1:0]     dmem_wdata,
    input  logic [XLEN-1:0]     dmem_rdata,
    output logic                dmem_rd,
    output logic                dmem_wr
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_W / 8);
    localparam int              BR_SHIFT = 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs1, rs2, rd;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   src1, src2;
    logic [XLEN-1:0]   alu_b, alu_res;
    logic              alu_zero;
    logic [XLEN-1:0]   wb_data;
    logic [XLEN-1:0]   pc_seq, pc_br;

    sc_decode #(.XLEN(XLEN)) i_decode (
        .instr   (imem_data),
        .ctrl    (ctrl),
        .rs1     (rs1),
        .rs2     (rs2),
        .rd      (rd),
        .imm_ext (imm_ext)
    );

    sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) i_regfile (
        .clk (clk),
        .rst (rst),
        .ra1 (rs1),
        .ra2 (rs2),
        .wa  (rd),
        .wd  (wb_data),
        .we  (ctrl.reg_we),
        .rd1 (src1),
        .rd2 (src2)
    );

    sc_alu #(.XLEN(XLEN)) i_alu (
        .opa  (src1),
        .opb  (alu_b),
        .op   (ctrl.alu_op),
        .res  (alu_res),
        .zero (alu_zero)
    );

    always_comb begin
        alu_b   = ctrl.sel_imm ? imm_ext : src2;
        wb_data = ctrl.wb_mem ? dmem_rdata : alu_res;
        pc_seq  = st_q.pc + STEP;
        pc_br   = pc_seq + (imm_ext << BR_SHIFT);

        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.is_branch && alu_zero) begin
            st_d.pc = pc_br;
        end else begin
            st_d.pc = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_res;
    assign dmem_wdata = src2;
    assign dmem_rd    = ctrl.mem_rd;
    assign dmem_wr    = ctrl.mem_wr;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [XLEN-1:0]  imem_addr,
    input logic [OPC_W-1:0] opc,
    input logic [IMM_W-1:0] imm,
    input logic             dmem_rd,
    input logic             dmem_wr
);

    localparam int EXT_W = XLEN - IMM_W;

    logic known_op;
    assign known_op = (opc == OP_ADD) || (opc == OP_BEQ) ||
                      (opc == OP_LOAD) || (opc == OP_STORE);

    // R10
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

    // R7
    a_r7_reset_pc: assert property (@(posedge clk)
        rst |=> (imem_addr == '0));

    // R7
    a_r7_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (opc != OP_BEQ) |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R8
    a_r8_branch_pc: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ) |=>
            ((imem_addr == $past(imem_addr) + XLEN'(4)) ||
             (imem_addr == $past(imem_addr) + XLEN'(4) +
                 ({{EXT_W{$past(imm[IMM_W-1])}}, $past(imm)} << 2))));

    // R3
    a_r3_load_strobe: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_LOAD) |-> (dmem_rd && !dmem_wr));

    // R4
    a_r4_store_strobe: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_STORE) |-> (dmem_wr && !dmem_rd));

    // R9
    a_r9_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        (!known_op) |-> (!dmem_rd && !dmem_wr));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .opc       (imem_data[31:26]),
    .imm       (imem_data[10:0]),
    .dmem_rd   (dmem_rd),
    .dmem_wr   (dmem_wr)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    localparam logic [5:0] C_ADD = 6'h00, C_BEQ = 6'h04, C_LD = 6'h23, C_ST = 6'h2B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_rd, dmem_wr;

    logic [31:0] imem [64];
    logic [31:0] dmem [16];
    logic [31:0] m_mem [16];
    logic [31:0] m_reg [32];
    logic [31:0] m_pc;
    string       pc_tag;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    sc_core i_sc_core (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dmem_rd(dmem_rd), .dmem_wr(dmem_wr)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];

    always @(posedge clk) begin
        if (dmem_wr) dmem[dmem_addr[5:2]] <= dmem_wdata;
    end

    function automatic logic [31:0] sx(input logic [10:0] v);
        return {{21{v[10]}}, v};
    endfunction

    function automatic logic [31:0] enc(input logic [5:0] op, input int a, input int b,
                                        input int d, input int imm);
        return {op, 5'(a), 5'(b), 5'(d), 11'(imm)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one reference step: check the current cycle, then advance the model
    task automatic step();
        logic [31:0] ins, a, b, ea;
        logic [5:0]  op;
        int          r1, r2, rd;
        ins = imem[m_pc[7:2]];
        op  = ins[31:26];
        r1  = int'(ins[25:21]);
        r2  = int'(ins[20:16]);
        rd  = int'(ins[15:11]);
        a   = (r1 == 0) ? 32'h0 : m_reg[r1];
        b   = (r2 == 0) ? 32'h0 : m_reg[r2];
        ea  = a + sx(ins[10:0]);
        chk(imem_addr === m_pc, pc_tag, "pc", imem_addr, m_pc);
        pc_tag = "R7";
        case (op)
            C_ADD: begin
                chk(!dmem_rd && !dmem_wr, "R2", "add strobes", {dmem_rd, dmem_wr}, 0);
                if (rd != 0) m_reg[rd] = a + b;
            end
            C_LD: begin
                chk(dmem_rd === 1'b1 && dmem_wr === 1'b0, "R3 R10", "load strobes",
                    {dmem_rd, dmem_wr}, 2);
                chk(dmem_addr === ea, ins[10] ? "R5" : "R3", "load addr", dmem_addr, ea);
                if (rd != 0) m_reg[rd] = m_mem[ea[5:2]];
            end
            C_ST: begin
                chk(dmem_wr === 1'b1 && dmem_rd === 1'b0, "R4 R10", "store strobes",
                    {dmem_rd, dmem_wr}, 1);
                chk(dmem_addr === ea, ins[10] ? "R5" : "R4", "store addr", dmem_addr, ea);
                chk(dmem_wdata === b, (r2 == 0) ? "R6" : "R1 R4", "store data", dmem_wdata, b);
                m_mem[ea[5:2]] = b;
            end
            C_BEQ: begin
                chk(!dmem_rd && !dmem_wr, "R8", "beq strobes", {dmem_rd, dmem_wr}, 0);
                pc_tag = "R8";
            end
            default: begin
                chk(!dmem_rd && !dmem_wr, "R9", "nop strobes", {dmem_rd, dmem_wr}, 0);
                pc_tag = "R9";
            end
        endcase
        if (op == C_BEQ && a == b) m_pc = m_pc + 32'd4 + (sx(ins[10:0]) << 2);
        else                       m_pc = m_pc + 32'd4;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = 32'h0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        for (int i = 0; i < 16; i++) m_mem[i] = dmem[i];
        pc_tag = "R7 reset";
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            if (i != 0) @(negedge clk);
            step();
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            int sel = int'($urandom_range(0, 99));
            int a = int'($urandom_range(0, 7));
            int b = int'($urandom_range(0, 7));
            int d = int'($urandom_range(0, 7));
            int imm = int'($urandom_range(0, 2047));
            if (sel < 35)       imem[i] = enc(C_ADD, a, b, d, imm);
            else if (sel < 55)  imem[i] = enc(C_LD, a, b, d, imm);
            else if (sel < 80)  imem[i] = enc(C_ST, a, b, d, imm);
            else if (sel < 90)  imem[i] = enc(C_BEQ, a, ($urandom_range(0, 1) != 0) ? a : b, d,
                                              int'($urandom_range(0, 12)) - 6);
            else                imem[i] = enc(6'($urandom_range(5, 34)), a, b, d, imm);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20260516));
        for (int i = 0; i < 16; i++) dmem[i] = $urandom;
        dmem[1]  = 32'h0000_1234;
        dmem[15] = 32'hF000_0001;
        for (int i = 0; i < 64; i++) imem[i] = enc(C_ADD, 0, 0, 0, 0);
        // directed program
        imem[0]  = enc(C_LD,  0, 0, 1, 4);     // r1 = mem[4]
        imem[1]  = enc(C_LD,  0, 0, 2, -4);    // r2 = mem[0xFFFFFFFC] (R5)
        imem[2]  = enc(C_ADD, 1, 2, 3, 0);     // r3 = r1 + r2
        imem[3]  = enc(C_ST,  0, 3, 0, 8);     // mem[8] = r3
        imem[4]  = enc(C_ADD, 1, 2, 0, 0);     // write to r0 discarded (R6)
        imem[5]  = enc(C_ST,  1, 0, 0, -12);   // stores r0 -> 0
        imem[6]  = enc(C_BEQ, 1, 1, 0, 1);     // taken, skips word 7
        imem[7]  = enc(C_ST,  0, 1, 0, 0);
        imem[8]  = enc(C_BEQ, 1, 2, 0, 5);     // not taken
        imem[9]  = enc(6'h3F, 1, 2, 3, 0);     // undefined opcode (R9)
        imem[10] = enc(C_ST,  0, 3, 0, 16);    // r3 unchanged by no-op
        imem[11] = enc(C_LD,  0, 0, 4, 8);     // r4 = stored sum
        imem[12] = enc(C_ST,  0, 4, 0, 20);
        imem[13] = enc(C_BEQ, 0, 0, 0, -14);   // back to 0
        do_reset();
        run(40);
        for (int p = 0; p < 3; p++) begin
            fill_random();
            @(negedge clk);
            do_reset();
            run(3000);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule